// File: doc/BRIEF.md
# Oscillation-Gated Trigger Generator

This block starts a self-oscillating push-pull converter by issuing short trigger pulses to the base of its low-side switching transistor. It works from a slow clock regime: an external ramp produces a one-cycle tick at the start of every period, nominally 250 µs, and each period begins with a clock pulse window, nominally 20 µs. At every tick the block may emit one trigger pulse of a fixed number of fast-clock cycles. Between ticks it counts the rising edges of the digitised feedback taken from the transistor base.

A period in which more than three feedback edges appear counts as an oscillating period. At the next tick the block reports the converter as oscillating and withholds the trigger for that whole period. When the load is missing, no feedback arrives, so a trigger is issued at every tick.

Triggers are held back until the supply-ready flag is high. They are also held back while the zero-crossing window or the dim blanking flag is active. If either of these becomes active during a pulse, the pulse is cut short. While dimming, a turn-off attenuation output stays on for the rest of the period after the clock pulse window.

Top module: `osc_trigger_gate`

## Requirements
- R1: While reset is asserted, and after it until the first tick, trigOut, oscOut and attenOut are all 0.
- R2: A trigger pulse starts in the cycle after a tick and lasts exactly TRIG_CYCLES cycles, unless it is cut. No trigger starts without a tick.
- R3: If more than OSC_LIMIT (default 3) rising edges of oscFb arrive during a period, then at the next tick oscOut goes to 1 and no trigger is emitted for that period.
- R4: The edge count starts again from zero at every tick. A period with exactly OSC_LIMIT edges still lets the next tick fire, and oscOut returns to 0.
- R5: No trigger starts at a tick while zcWin or dimBlank is high. If either input goes high during a pulse, trigOut is 0 from the following cycle.
- R6: No trigger starts, and a running pulse is cut, while supplyOk is 0.
- R7: attenOut is 1 exactly when dimBlank and supplyOk are both 1, outside the clock pulse window. The window is the tick cycle plus the next PULSE_CYCLES-1 cycles, so attenuation lasts the period minus PULSE_CYCLES.
- R8: With no feedback edges at all, a trigger is issued at every unblocked tick.
- R9: oscOut changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle strobe that starts each clock-regime period |
| oscFb | input | 1 | Digitised oscillation feedback from the transistor base |
| supplyOk | input | 1 | Supply has reached its start threshold |
| zcWin | input | 1 | Mains zero-crossing window is active |
| dimBlank | input | 1 | Dim blanking interval is active |
| trigOut | output | 1 | Trigger pulse to the switching transistor |
| oscOut | output | 1 | The previous period was recognised as oscillating |
| attenOut | output | 1 | Turn-off attenuation drive |

## Verification
The assertions assume that ticks are single-cycle strobes spaced further apart than both TRIG_CYCLES and PULSE_CYCLES. Under that assumption a trigger can never overlap the next tick, and the clock pulse window always closes inside its own period. The stimulus uses a fixed period of 40 fast cycles, with a 4-cycle trigger and an 8-cycle window. Feedback edges are placed only from the third cycle of a period onward and end well before the next tick, so every edge belongs to a single, known period.

// File: rtl/oscgate_pkg.sv
package oscgate_pkg;
  // Strobes from the gating control to the counting datapath
  typedef struct packed {
    logic periodStart;  // tick seen: restart period bookkeeping
    logic fireTrig;     // load the trigger width counter
    logic cutTrig;      // abort a running trigger
    logic attenEn;      // attenuation requested (before window masking)
  } gateCtl_t;
endpackage

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import oscgate_pkg::*;
(
  input  logic     tickIn,
  input  logic     supplyOk,
  input  logic     zcWin,
  input  logic     dimBlank,
  input  logic     oscSeen,
  input  logic     trigBusy,
  output gateCtl_t ctl
);
  logic blocked;

  always_comb begin
    blocked         = zcWin | dimBlank | ~supplyOk;
    ctl.periodStart = tickIn;
    ctl.fireTrig    = tickIn & ~blocked & ~oscSeen;
    ctl.cutTrig     = trigBusy & blocked;
    ctl.attenEn     = supplyOk & dimBlank & ~tickIn;
  end
endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import oscgate_pkg::*;
#(
  parameter int TRIG_CYCLES  = 4,
  parameter int PULSE_CYCLES = 8,
  parameter int OSC_LIMIT    = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscFb,
  input  gateCtl_t ctl,
  output logic     oscSeen,
  output logic     trigBusy,
  output logic     trigOut,
  output logic     oscOut,
  output logic     attenOut
);
  localparam int SAT = OSC_LIMIT + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam int TW  = $clog2(TRIG_CYCLES + 1);
  localparam int PW  = $clog2(PULSE_CYCLES + 1);

  logic          oscPrev;
  logic [CW-1:0] edgeCnt;
  logic          oscFlag;
  logic [TW-1:0] trigCnt;
  logic [PW-1:0] pulseCnt;
  logic          primed;
  logic          rise;
  logic          inWindow;

  assign rise     = oscFb & ~oscPrev;
  assign oscSeen  = (edgeCnt == CW'(SAT));
  assign trigBusy = (trigCnt != '0);
  assign inWindow = (pulseCnt != '0);

  // Feedback edge counter, restarted each period, saturating above the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscPrev <= 1'b0;
      edgeCnt <= '0;
      oscFlag <= 1'b0;
    end else begin
      oscPrev <= oscFb;
      if (ctl.periodStart) begin
        oscFlag <= oscSeen;
        edgeCnt <= rise ? CW'(1) : '0;
      end else if (rise && !oscSeen) begin
        edgeCnt <= edgeCnt + CW'(1);
      end
    end
  end

  // Trigger width counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigCnt <= '0;
    end else if (ctl.fireTrig) begin
      trigCnt <= TW'(TRIG_CYCLES);
    end else if (ctl.cutTrig) begin
      trigCnt <= '0;
    end else if (trigBusy) begin
      trigCnt <= trigCnt - TW'(1);
    end
  end

  // Clock pulse window: the tick cycle plus PULSE_CYCLES-1 following cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      primed   <= 1'b0;
    end else if (ctl.periodStart) begin
      pulseCnt <= PW'(PULSE_CYCLES - 1);
      primed   <= 1'b1;
    end else if (inWindow) begin
      pulseCnt <= pulseCnt - PW'(1);
    end
  end

  assign trigOut  = trigBusy;
  assign oscOut   = oscFlag;
  assign attenOut = ctl.attenEn & primed & ~inWindow;
endmodule

// File: rtl/osc_trigger_gate.sv
module osc_trigger_gate
  import oscgate_pkg::*;
#(
  parameter int TRIG_CYCLES  = 4,
  parameter int PULSE_CYCLES = 8,
  parameter int OSC_LIMIT    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickIn,
  input  logic oscFb,
  input  logic supplyOk,
  input  logic zcWin,
  input  logic dimBlank,
  output logic trigOut,
  output logic oscOut,
  output logic attenOut
);
  gateCtl_t ctl;
  logic     oscSeen;
  logic     trigBusy;

  gate_ctrl u_ctrl (
    .tickIn   (tickIn),
    .supplyOk (supplyOk),
    .zcWin    (zcWin),
    .dimBlank (dimBlank),
    .oscSeen  (oscSeen),
    .trigBusy (trigBusy),
    .ctl      (ctl)
  );

  gate_datapath #(
    .TRIG_CYCLES  (TRIG_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES),
    .OSC_LIMIT    (OSC_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscFb    (oscFb),
    .ctl      (ctl),
    .oscSeen  (oscSeen),
    .trigBusy (trigBusy),
    .trigOut  (trigOut),
    .oscOut   (oscOut),
    .attenOut (attenOut)
  );
endmodule

// File: rtl/osc_trigger_gate_chk.sv
module osc_trigger_gate_chk #(
  parameter int TRIG_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic tickIn,
  input logic supplyOk,
  input logic zcWin,
  input logic dimBlank,
  input logic trigOut,
  input logic oscOut,
  input logic attenOut
);
  logic [15:0] hiRun;

  always_ff @(posedge clk) begin
    if (!rstN) hiRun <= '0;
    else if (!trigOut) hiRun <= '0;
    else if (hiRun != 16'hFFFF) hiRun <= hiRun + 16'd1;
  end

  // R2: a trigger only starts right after a tick
  a_r2_trig_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> $past(tickIn));

  // R2: a trigger never lasts longer than TRIG_CYCLES
  a_r2_trig_width: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (hiRun < 16'(TRIG_CYCLES)));

  // R3: no trigger starts in a period flagged as oscillating
  a_r3_no_trig_when_osc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> !oscOut);

  // R5 / R6: a blocking condition removes the trigger by the next cycle
  a_r5_blocked_cuts: assert property (@(posedge clk) disable iff (!rstN)
    (zcWin || dimBlank || !supplyOk) |=> !trigOut);

  // R7: attenuation is off in the tick cycle and never overlaps a trigger
  a_r7_atten_off_at_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |-> !attenOut);

  a_r7_atten_excl_trig: assert property (@(posedge clk) disable iff (!rstN)
    attenOut |-> !trigOut);

  // R9: oscillation status only moves after a tick
  a_r9_osc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(oscOut));
endmodule

bind osc_trigger_gate osc_trigger_gate_chk #(.TRIG_CYCLES(TRIG_CYCLES)) u_chk (.*);

// File: tb/osc_trigger_gate_test.sv
module osc_trigger_gate_test;
  localparam int TRIG  = 4;
  localparam int PULSE = 8;
  localparam int PER   = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, oscFb = 1'b0, supplyOk = 1'b1, zcWin = 1'b0, dimBlank = 1'b1;
  logic trigOut, oscOut, attenOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int prevEdges = 0;

  typedef struct {
    int    trigN;
    int    attN;
    bit    osc;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  osc_trigger_gate #(.TRIG_CYCLES(TRIG), .PULSE_CYCLES(PULSE), .OSC_LIMIT(3)) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .oscFb(oscFb), .supplyOk(supplyOk),
    .zcWin(zcWin), .dimBlank(dimBlank), .trigOut(trigOut), .oscOut(oscOut),
    .attenOut(attenOut));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: one period of PER cycles; dimBlank rises at cycle dimFrom (PER = never)
  task automatic runPeriod(input int nEdges, input bit zc, input int dimFrom,
                           input bit sup, input string tag);
    exp_t e;
    bit blockedAtTick;
    blockedAtTick = zc || !sup || (dimFrom == 0);
    e.osc   = (prevEdges > 3);
    e.trigN = (!blockedAtTick && prevEdges <= 3) ? ((dimFrom < TRIG) ? dimFrom : TRIG) : 0;
    e.attN  = (sup && dimFrom < PER) ? PER - ((dimFrom > PULSE) ? dimFrom : PULSE) : 0;
    e.tag   = tag;
    sbq.push_back(e);
    for (int c = 0; c < PER; c++) begin
      @(posedge clk); #1;
      tickIn   = (c == 0);
      zcWin    = zc;
      supplyOk = sup;
      dimBlank = (c >= dimFrom);
      oscFb    = (c >= 2 && c < 2 + 2 * nEdges) ? ((c - 2) % 2 == 0) : 1'b0;
    end
    prevEdges = nEdges;
  endtask

  // Monitor: at each tick, pop the expected item and measure the period
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && tickIn) begin
        exp_t e;
        int tN, aN;
        bit oscFirst;
        tN = 0; aN = 0; oscFirst = 1'b0;
        if (sbq.size() == 0) begin
          check(1'b0, "scoreboard empty at tick R2", 0, 1);
          e.trigN = 0; e.attN = 0; e.osc = 1'b0; e.tag = "none";
        end else begin
          e = sbq.pop_front();
        end
        for (int k = 0; k < PER; k++) begin
          if (k > 0) @(negedge clk);
          if (trigOut) tN++;
          if (attenOut) aN++;
          if (k == 1) oscFirst = oscOut;
          if (k == PER - 1)
            check(oscOut == oscFirst, {e.tag, " R9 osc stable"}, int'(oscOut), int'(oscFirst));
        end
        check(tN == e.trigN, {e.tag, " trig cycles"}, tN, e.trigN);
        check(aN == e.attN, {e.tag, " atten cycles R7"}, aN, e.attN);
        check(oscFirst == e.osc, {e.tag, " oscOut"}, int'(oscFirst), int'(e.osc));
      end
    end
  end

  initial begin
    repeat (2000000 / 4 / 100) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (all requirements) actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs low in reset, even with dim and supply asserted
    repeat (3) @(negedge clk);
    check(!trigOut && !oscOut && !attenOut, "R1 outputs in reset", int'({trigOut, oscOut, attenOut}), 0);
    @(posedge clk); #1; rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!trigOut && !oscOut && !attenOut, "R1 outputs before first tick", int'({trigOut, oscOut, attenOut}), 0);

    runPeriod(0, 0, PER, 1, "R8 no load p1 R2");
    runPeriod(0, 0, PER, 1, "R8 no load p2");
    runPeriod(5, 0, PER, 1, "R2 trig then five edges");
    runPeriod(0, 0, PER, 1, "R3 oscillating suppresses");
    runPeriod(3, 0, PER, 1, "R4 after osc, three edges");
    runPeriod(4, 0, PER, 1, "R4 three edges still fires");
    runPeriod(0, 1, PER, 1, "R5 zc window after osc R3");
    runPeriod(0, 0, PER, 1, "R4 count cleared");
    runPeriod(0, 1, PER, 1, "R5 zc window blocks");
    runPeriod(0, 0, 0, 1, "R5 dim whole period R7");
    runPeriod(0, 0, 2, 1, "R5 dim cuts pulse R7");
    runPeriod(0, 0, 20, 1, "R7 late dim");
    runPeriod(0, 0, 0, 0, "R6 supply low");
    runPeriod(6, 0, PER, 0, "R6 supply low with edges");
    runPeriod(0, 0, PER, 1, "R3 osc seen while supply low");
    runPeriod(0, 0, PER, 1, "R8 no load resumes");

    @(posedge clk); #1; tickIn = 1'b0;
    repeat (PER + 4) @(negedge clk);
    check(sbq.size() == 0, "R2 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule